// File: doc/BRIEF.md
# Receive Packet Buffer with Status Queue

This block sits between the receive side of a MAC and a host reader. The MAC side hands over packets one byte per cycle and marks the final byte with a 4-bit error code. The block stores the bytes in a circular byte store and keeps a small queue of per-packet status entries. A packet becomes visible to the host only when its final byte is committed, so the host never sees a partial packet.

The host first reads a 16-bit status word for the oldest packet. This word gives the empty flag, the error code and the byte count. The host then pulls the data two bytes per read and removes the packet with a discard command. Discard also drops any bytes of the packet that were not read. The block refuses new packets when the byte store is full or when the packet queue is at its limit, and such packets are lost whole. Reading beyond the end of the oldest packet is a fatal host error, and only a receive reset or the global reset clears it.

Top module: `rx_pkt_fifo`

## Requirements
- R1: After `rst`, `rx_status` reads 16'h8000 and `rx_receiving`, `rx_complete`, `rx_overrun`, `rx_stat_overrun`, `rx_underrun` and `adapter_fail` are all low.
- R2: When at least one packet is held, `rx_status` has bit 15 clear, bits 14..11 equal to the 4-bit code given with that packet's final byte, passed through unchanged (for example 1101 CRC, 1011 runt, 0010 dribble), and bits 10..0 equal to the packet's byte count.
- R3: A `rd_req` pulse returns, on `rd_data` in the next cycle, the next unread byte of the oldest packet in bits 7..0 and the byte after it in bits 15..8. When only one byte remains, bits 15..8 are zero.
- R4: Packets come out oldest first. A command with `cmd_op` = 8 removes the oldest packet together with its unread bytes, and `rx_status` shows the next packet, or 16'h8000, in the following cycle.
- R5: While `MAX_PKTS` packets are held, `rx_stat_overrun` is high and a new packet is dropped whole. The flag clears once a packet is discarded.
- R6: While the stored bytes, including those of a packet still being written, fill all `DEPTH` bytes, `rx_overrun` is high and a new packet is dropped whole. The flag clears once the host reads bytes out.
- R7: A packet that runs out of byte storage part-way is dropped whole. Its bytes are released, so `rx_overrun` falls again, and packets queued before it are unaffected.
- R8: A `rd_req` when the oldest packet has no unread bytes, or when no packet is held, sets `rx_underrun` and `adapter_fail`. Both stay set until `cmd_op` = 5 (receive reset) or `rst`.
- R9: A receive reset (`cmd_op` = 5) empties the buffer and the status queue, and the remaining bytes of a packet in progress are dropped up to its final byte.
- R10: `rx_receiving` is high from the cycle after a packet's first accepted byte until the cycle after its final byte.
- R11: `rx_complete` is high for exactly one cycle after each packet commit, and stays low for dropped packets.
- R12: A discard command while no packet is held has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| wr_valid | input | 1 | A byte from the MAC side is present |
| wr_data | input | 8 | Received byte |
| wr_last | input | 1 | This byte ends the packet |
| wr_code | input | 4 | Error code for the packet, sampled with the final byte |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 5 | Command opcode: 5 receive reset, 8 discard oldest packet |
| rd_req | input | 1 | Host read of one 16-bit data word |
| rd_data | output | 16 | Data word, valid in the cycle after `rd_req` |
| rx_status | output | 16 | Status word of the oldest packet |
| rx_receiving | output | 1 | A packet is being written |
| rx_complete | output | 1 | One-cycle pulse per committed packet |
| rx_overrun | output | 1 | Byte storage full |
| rx_stat_overrun | output | 1 | Packet queue at its limit |
| rx_underrun | output | 1 | Sticky host over-read flag |
| adapter_fail | output | 1 | Failure indication raised by an over-read |

## Verification
The assertions assume that the MAC side never presents a final byte without a code and never changes a byte in the middle of a cycle. They also assume that `DEPTH` is a power of two no larger than 1024, so that a byte count always fits in 11 bits. The stimulus drives every input on the falling edge, keeps all packets within the default 64-byte store, and never issues a discard and a read in the same cycle. A read is placed after its status check, so the status and data results can be compared against values computed from the packet length, code and base byte.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int LEN_W  = 11;
  localparam int CODE_W = 4;

  localparam logic [4:0] OP_RX_RESET = 5'd5;
  localparam logic [4:0] OP_DISCARD  = 5'd8;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [LEN_W-1:0]  len;
  } pkt_stat_t;
endpackage

// File: rtl/rxq_byte_store.sv
module rxq_byte_store #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr_lo,
  input  logic [AW-1:0] raddr_hi,
  output logic [7:0]    q_lo,
  output logic [7:0]    q_hi
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q_lo <= mem[raddr_lo];
    q_hi <= mem[raddr_hi];
  end
endmodule

// File: rtl/rxq_stat_queue.sv
module rxq_stat_queue
  import rxq_pkg::*;
#(
  parameter int N  = 8,
  parameter int QA = (N > 1) ? $clog2(N) : 1,
  parameter int CW = $clog2(N + 1)
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      clr,
  input  logic      push,
  input  pkt_stat_t push_stat,
  input  logic      pop,
  output pkt_stat_t top,
  output logic [CW-1:0] count
);
  pkt_stat_t       ent [N];
  logic [QA-1:0]   head, tail;

  function automatic logic [QA-1:0] nxt(input logic [QA-1:0] p);
    return (p == QA'(N - 1)) ? '0 : p + QA'(1);
  endfunction

  assign top = ent[head];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) begin
        ent[tail] <= push_stat;
        tail      <= nxt(tail);
      end
      if (pop) head <= nxt(head);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  AST_NO_POP_EMPTY:  assert property (@(posedge clk) disable iff (rst) pop |-> count != '0);       // R12
  AST_NO_PUSH_FULL:  assert property (@(posedge clk) disable iff (rst) push |-> count != CW'(N));   // R5
endmodule

// File: rtl/rxq_wr_ctl.sv
module rxq_wr_ctl
  import rxq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int MAX_PKTS = 8,
  parameter int AW       = $clog2(DEPTH),
  parameter int PW       = AW + 1,
  parameter int CW       = $clog2(MAX_PKTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  input  logic              wr_last,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [PW-1:0]     rd_ptr,
  input  logic [CW-1:0]     pkt_cnt,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic              push,
  output pkt_stat_t         push_stat,
  output logic [PW-1:0]     wr_ptr,
  output logic              in_pkt,
  output logic              complete
);
  logic [PW-1:0]    commit_ptr;
  logic [LEN_W-1:0] len, len_next;
  logic             dropping, full, starting, gate_ok, accept;

  assign full      = (wr_ptr - rd_ptr) == PW'(DEPTH);
  assign starting  = wr_valid & ~in_pkt & ~dropping & ~clr;
  assign gate_ok   = ~full & (pkt_cnt < CW'(MAX_PKTS));
  assign accept    = ~clr & wr_valid & ((starting & gate_ok) | (in_pkt & ~full));
  assign len_next  = in_pkt ? len + LEN_W'(1) : LEN_W'(1);

  assign mem_we    = accept;
  assign mem_waddr = wr_ptr[AW-1:0];
  assign mem_wdata = wr_data;
  assign push      = accept & wr_last;
  assign push_stat = '{code: wr_code, len: len_next};

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      commit_ptr <= '0;
      len        <= '0;
      in_pkt     <= 1'b0;
      dropping   <= 1'b0;
      complete   <= 1'b0;
    end else begin
      complete <= push;
      if (clr) begin
        wr_ptr     <= '0;
        commit_ptr <= '0;
        len        <= '0;
        in_pkt     <= 1'b0;
        dropping   <= (in_pkt | dropping | wr_valid) & ~(wr_valid & wr_last);
      end else if (wr_valid) begin
        if (accept) begin
          wr_ptr <= wr_ptr + PW'(1);
          len    <= len_next;
          if (wr_last) begin
            commit_ptr <= wr_ptr + PW'(1);
            in_pkt     <= 1'b0;
          end else begin
            in_pkt     <= 1'b1;
          end
        end else if (in_pkt) begin
          wr_ptr   <= commit_ptr;
          in_pkt   <= 1'b0;
          len      <= '0;
          dropping <= ~wr_last;
        end else if (dropping) begin
          if (wr_last) dropping <= 1'b0;
        end else begin
          dropping <= ~wr_last;
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (wr_ptr - rd_ptr) <= PW'(DEPTH)); // R6
  AST_START_GATED: assert property (@(posedge clk) disable iff (rst) $rose(in_pkt) |-> $past(pkt_cnt) < CW'(MAX_PKTS)); // R5
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (rst) dropping && !clr |-> !mem_we); // R7
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int MAX_PKTS = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_valid,
  input  logic [7:0]  wr_data,
  input  logic        wr_last,
  input  logic [3:0]  wr_code,
  input  logic        cmd_valid,
  input  logic [4:0]  cmd_op,
  input  logic        rd_req,
  output logic [15:0] rd_data,
  output logic [15:0] rx_status,
  output logic        rx_receiving,
  output logic        rx_complete,
  output logic        rx_overrun,
  output logic        rx_stat_overrun,
  output logic        rx_underrun,
  output logic        adapter_fail
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int CW = $clog2(MAX_PKTS + 1);

  logic              mem_we, push, is_discard, is_rxrst, q_empty, do_pop, rd_ok, rd_bad, hi_keep;
  logic [AW-1:0]     mem_waddr;
  logic [7:0]        mem_wdata, q_lo, q_hi;
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     pkt_cnt;
  logic [LEN_W-1:0]  consumed, left, step;
  pkt_stat_t         push_stat, q_top;

  assign is_discard = cmd_valid & (cmd_op == OP_DISCARD);
  assign is_rxrst   = cmd_valid & (cmd_op == OP_RX_RESET);
  assign q_empty    = (pkt_cnt == '0);
  assign left       = q_top.len - consumed;
  assign step       = (left >= LEN_W'(2)) ? LEN_W'(2) : LEN_W'(1);
  assign do_pop     = is_discard & ~q_empty;
  assign rd_ok      = rd_req & ~is_discard & ~is_rxrst & ~q_empty & (left != '0);
  assign rd_bad     = rd_req & ~is_discard & ~is_rxrst & (q_empty | (left == '0));

  rxq_wr_ctl #(.DEPTH(DEPTH), .MAX_PKTS(MAX_PKTS), .AW(AW), .PW(PW), .CW(CW)) u_wr (
    .clk(clk), .rst(rst), .clr(is_rxrst),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last), .wr_code(wr_code),
    .rd_ptr(rd_ptr), .pkt_cnt(pkt_cnt),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .push(push), .push_stat(push_stat), .wr_ptr(wr_ptr),
    .in_pkt(rx_receiving), .complete(rx_complete)
  );

  rxq_byte_store #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_lo(rd_ptr[AW-1:0]), .raddr_hi(rd_ptr[AW-1:0] + AW'(1)),
    .q_lo(q_lo), .q_hi(q_hi)
  );

  rxq_stat_queue #(.N(MAX_PKTS), .CW(CW)) u_q (
    .clk(clk), .rst(rst), .clr(is_rxrst),
    .push(push), .push_stat(push_stat), .pop(do_pop),
    .top(q_top), .count(pkt_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst || is_rxrst) begin
      rd_ptr      <= '0;
      consumed    <= '0;
      rx_underrun <= 1'b0;
      hi_keep     <= 1'b0;
    end else begin
      if (do_pop) begin
        rd_ptr   <= rd_ptr + PW'(left);
        consumed <= '0;
      end else if (rd_ok) begin
        rd_ptr   <= rd_ptr + PW'(step);
        consumed <= consumed + step;
        hi_keep  <= (left >= LEN_W'(2));
      end
      if (rd_bad) rx_underrun <= 1'b1;
    end
  end

  assign adapter_fail    = rx_underrun;
  assign rd_data         = {hi_keep ? q_hi : 8'h00, q_lo};
  assign rx_status       = q_empty ? 16'h8000 : {1'b0, q_top.code, q_top.len};
  assign rx_overrun      = (wr_ptr - rd_ptr) == PW'(DEPTH);
  assign rx_stat_overrun = (pkt_cnt == CW'(MAX_PKTS));

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst) rx_underrun && !is_rxrst |=> rx_underrun); // R8
  AST_COMPLETE_QUEUED: assert property (@(posedge clk) disable iff (rst) rx_complete |-> !q_empty);                 // R11
  AST_PKT_LIMIT:       assert property (@(posedge clk) disable iff (rst) pkt_cnt <= CW'(MAX_PKTS));                 // R5
  AST_READ_IN_PACKET:  assert property (@(posedge clk) disable iff (rst) rd_ok |=> consumed <= q_top.len);          // R3
endmodule

// File: tb/rx_pkt_fifo_bench.sv
`timescale 1ns/1ps
module rx_pkt_fifo_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0, wr_last = 1'b0, cmd_valid = 1'b0, rd_req = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  wr_code = '0;
  logic [4:0]  cmd_op = '0;
  logic [15:0] rd_data, rx_status;
  logic        rx_receiving, rx_complete, rx_overrun, rx_stat_overrun, rx_underrun, adapter_fail;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  rx_pkt_fifo u_rx_pkt_fifo (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last),
    .wr_code(wr_code), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .rd_req(rd_req),
    .rd_data(rd_data), .rx_status(rx_status), .rx_receiving(rx_receiving),
    .rx_complete(rx_complete), .rx_overrun(rx_overrun), .rx_stat_overrun(rx_stat_overrun),
    .rx_underrun(rx_underrun), .adapter_fail(adapter_fail)
  );

  // packet vectors: {code[3:0], len[10:0]}
  localparam logic [14:0] VEC [6] = '{
    {4'h0, 11'd1}, {4'hD, 11'd2}, {4'h2, 11'd7},
    {4'hC, 11'd5}, {4'h8, 11'd16}, {4'hB, 11'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input int len, input logic [3:0] code, input logic [7:0] base);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      wr_valid = 1'b1; wr_data = base + 8'(i); wr_last = (i == len - 1); wr_code = code;
    end
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
  endtask

  task automatic rd_word(output logic [15:0] d);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0; d = rd_data;
  endtask

  task automatic cmd(input logic [4:0] op);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  function automatic logic [15:0] exp_word(input int len, input logic [7:0] base, input int k);
    logic [7:0] lo, hi;
    lo = base + 8'(2 * k);
    hi = (2 * k + 1 < len) ? base + 8'(2 * k + 1) : 8'h00;
    return {hi, lo};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    int len;
    logic [3:0] code;
    logic [7:0] base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", rx_status, 16'h8000);
    chk("R1 flags", {rx_receiving, rx_complete, rx_overrun, rx_stat_overrun, rx_underrun, adapter_fail}, 6'b0);

    // vector table: R2 status, R3 data lanes, R4 discard, R11 pulse
    for (int i = 0; i < 6; i++) begin
      len = int'(VEC[i][10:0]); code = VEC[i][14:11]; base = 8'(8'h10 * i + 8'h03);
      send(len, code, base);
      chk("R11 complete pulse", rx_complete, 1'b1);
      chk("R2 status", rx_status, {1'b0, code, 11'(len)});
      @(negedge clk);
      chk("R11 single pulse", rx_complete, 1'b0);
      for (int k = 0; k < (len + 1) / 2; k++) begin
        rd_word(w);
        chk("R3 data word", w, exp_word(len, base, k));
      end
      cmd(5'd8);
      chk("R4 empty after discard", rx_status, 16'h8000);
    end

    // R4 ordering and discard of unread bytes
    send(4, 4'h0, 8'hA0); send(4, 4'hD, 8'hB0); send(4, 4'hC, 8'hC0);
    rd_word(w); chk("R4 first packet", w, 16'hA1A0);
    cmd(5'd8);
    chk("R4 second status", rx_status, {1'b0, 4'hD, 11'd4});
    rd_word(w); chk("R4 second packet", w, 16'hB1B0);
    cmd(5'd8);
    rd_word(w); chk("R4 third packet", w, 16'hC1C0);
    cmd(5'd8);
    chk("R4 drained", rx_status, 16'h8000);

    // R12 discard on empty
    cmd(5'd8);
    chk("R12 status", rx_status, 16'h8000);
    send(2, 4'h0, 8'h55);
    chk("R12 status after send", rx_status, {1'b0, 4'h0, 11'd2});
    rd_word(w); chk("R12 data", w, 16'h5655);

    // R8 underrun
    chk("R8 no underrun yet", rx_underrun, 1'b0);
    rd_word(w);
    chk("R8 underrun set", {rx_underrun, adapter_fail}, 2'b11);
    cmd(5'd8);
    send(2, 4'h0, 8'h60);
    chk("R8 sticky", {rx_underrun, adapter_fail}, 2'b11);
    cmd(5'd5);
    chk("R8 cleared by rx reset", {rx_underrun, adapter_fail}, 2'b00);
    chk("R9 empty after rx reset", rx_status, 16'h8000);

    // R5 packet limit
    for (int p = 0; p < 8; p++) send(2, 4'h0, 8'(8'h20 + 2 * p));
    chk("R5 limit flag", rx_stat_overrun, 1'b1);
    send(2, 4'h9, 8'hE0);
    chk("R5 dropped no pulse", rx_complete, 1'b0);
    chk("R5 top unchanged", rx_status, {1'b0, 4'h0, 11'd2});
    cmd(5'd8);
    chk("R5 flag clears", rx_stat_overrun, 1'b0);
    send(2, 4'h9, 8'hE0);
    chk("R5 accepted again", rx_complete, 1'b1);
    rd_word(w); chk("R5 order kept", w, 16'h2322);
    cmd(5'd5);

    // R6 byte storage full
    for (int p = 0; p < 4; p++) send(16, 4'h0, 8'(8'h40 * p));
    chk("R6 full flag", rx_overrun, 1'b1);
    send(3, 4'h0, 8'hF0);
    chk("R6 dropped no pulse", rx_complete, 1'b0);
    chk("R6 still full", rx_overrun, 1'b1);
    rd_word(w);
    chk("R6 data", w, 16'h0100);
    chk("R6 flag clears", rx_overrun, 1'b0);
    cmd(5'd5);

    // R7 overflow part-way
    send(60, 4'h0, 8'h00);
    send(10, 4'hD, 8'h80);
    chk("R7 no pulse", rx_complete, 1'b0);
    chk("R7 space released", rx_overrun, 1'b0);
    chk("R7 earlier intact", rx_status, {1'b0, 4'h0, 11'd60});
    cmd(5'd8);
    chk("R7 nothing queued", rx_status, 16'h8000);
    send(2, 4'h0, 8'h40);
    rd_word(w); chk("R7 next data", w, 16'h4140);
    cmd(5'd5);

    // R10 receiving flag
    @(negedge clk); wr_valid = 1'b1; wr_data = 8'h01; wr_last = 1'b0;
    @(negedge clk); chk("R10 high after first byte", rx_receiving, 1'b1);
    wr_data = 8'h02;
    @(negedge clk); chk("R10 still high", rx_receiving, 1'b1);
    wr_data = 8'h03; wr_last = 1'b1; wr_code = 4'h0;
    @(negedge clk); wr_valid = 1'b0; wr_last = 1'b0;
    chk("R10 low after last", rx_receiving, 1'b0);

    // R9 rx reset with held packet and mid-packet
    cmd(5'd5);
    chk("R9 held cleared", rx_status, 16'h8000);
    @(negedge clk); wr_valid = 1'b1; wr_data = 8'h90; wr_last = 1'b0;
    @(negedge clk); wr_data = 8'h91;
    @(negedge clk); wr_valid = 1'b0; cmd_valid = 1'b1; cmd_op = 5'd5;
    @(negedge clk); cmd_valid = 1'b0; wr_valid = 1'b1; wr_data = 8'h92;
    @(negedge clk); wr_data = 8'h93; wr_last = 1'b1;
    @(negedge clk); wr_valid = 1'b0; wr_last = 1'b0;
    chk("R9 tail dropped", {rx_complete, rx_receiving}, 2'b00);
    chk("R9 nothing queued", rx_status, 16'h8000);
    send(2, 4'h2, 8'h70);
    chk("R9 next status", rx_status, {1'b0, 4'h2, 11'd2});
    rd_word(w); chk("R9 next data", w, 16'h7170);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule